// File: doc/BRIEF.md
# Residue-to-Binary Mixed-Radix Converter

This block turns a number held as four residues, modulo 128, 31, 63 and 127, back into an ordinary 25-bit two's complement integer. It works in two phases. The first phase finds the mixed-radix digits. In each round it removes the digit just found from the channels that remain, then multiplies those channels by the modular inverse of the modulus it has just used up. All remaining channels move in the same cycle. The second phase rebuilds the weighted value from the four digits using shifts, one addition chain and one subtraction.

The number range is M = 128·31·63·127 = 31,747,968. A residue value x with M/2 ≤ x < M stands for the negative number x − M. The block reports that number together with a sign flag. The channel order 128, 31, 63, 127 is chosen on purpose. With this order, every inverse needed in the digit phase is a power of two or its negative, except for 1/31 modulo 127. Also, the mod-128 residue gives the low seven bits of the result directly.

A caller presents the four residues and pulses `start` while the block is idle. Seven clock edges later, `done` pulses for one cycle. The result stays on `value` and `is_neg` until the next conversion completes.

Top module: `rns_mr_converter`

## Requirements
- R1: While reset is high and right after it is released, `busy`, `done`, `is_neg` and `value` are all zero.
- R2: When `start` is high while `busy` is low, the block accepts the request on that clock edge, and `busy` goes high after that edge. After the seventh edge following the accepting edge, `done` is high for exactly one cycle and `busy` is low at the same time.
- R3: A `start` pulse that arrives while `busy` is high is ignored. The running conversion returns the result for the residues captured when it was accepted, and no second conversion follows it.
- R4: For residues of x with 0 ≤ x < M/2 = 15,873,984, `value` equals x and `is_neg` is 0.
- R5: For residues of x with M/2 ≤ x < M, `value` equals x − M as a 25-bit two's complement number, and `is_neg` is 1. So `is_neg` always equals bit 24 of `value`.
- R6: Bits 6..0 of `value` always equal the mod-128 residue input.
- R7: `value` and `is_neg` keep the last completed result while residue inputs change without an accepted `start`.
- R8: The range ends convert exactly: 0 gives 0, M/2 − 1 gives +15,873,983, M/2 gives −15,873,984, and M − 1 gives −1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion; accepted only while idle |
| res_m128 | input | 7 | Residue modulo 128 |
| res_m31 | input | 5 | Residue modulo 31, least form (0..30) |
| res_m63 | input | 6 | Residue modulo 63, least form (0..62) |
| res_m127 | input | 7 | Residue modulo 127, least form (0..126) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is loaded |
| value | output | 25 | Signed binary result |
| is_neg | output | 1 | Result is negative |

## Verification
Each lane register feeds every later digit. A wrong subtraction or a wrong inverse therefore shows up as a wrong upper digit, and the error becomes visible in bits 7 and above of `value` at the very next `done` pulse. A sequencer fault shows up as `done` arriving at the wrong edge, or as a second pulse after a `start` that should have been ignored. The bench round-trips directed and pseudo-random signed values through its own residue encoder and compares both the recovered value and the sign flag. It also drives the four ends of the range, where a single-unit error in the sign threshold changes the sign.

// File: rtl/rns_mr_pkg.sv
package rns_mr_pkg;

    // channel bit widths; moduli follow as 2^k or 2^k - 1
    localparam int NCH  = 4;
    localparam int K1   = 7;
    localparam int K2   = 5;
    localparam int K3   = 6;
    localparam int K4   = 7;
    localparam int MOD1 = 1 << K1;
    localparam int MOD2 = (1 << K2) - 1;
    localparam int MOD3 = (1 << K3) - 1;
    localparam int MOD4 = (1 << K4) - 1;

    localparam int RW     = K1;                          // lane register width
    localparam int MW     = 2 * RW + 2;                  // modular temp width
    localparam int OUTW   = 25;                          // binary result width
    localparam int TW     = OUTW - K1;                   // rebuild adder width
    localparam int RANGE_M = MOD1 * MOD2 * MOD3 * MOD4;
    localparam int HALF_M  = RANGE_M / 2;
    localparam int STEPS   = 2 * (NCH - 1);              // digit-phase steps
    localparam int CONV_CYCLES = STEPS + 2;              // accept .. done

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic [RW-1:0] p1;
        logic [RW-1:0] p2;
        logic [RW-1:0] p3;
        logic [RW-1:0] p4;
    } digits_t;

    function automatic int modulus(int idx);
        case (idx)
            0:       return MOD1;
            1:       return MOD2;
            2:       return MOD3;
            default: return MOD4;
        endcase
    endfunction

    // elaboration-time search for a modular inverse
    function automatic int modinv(int a, int m);
        int r;
        r = 0;
        for (int k = 1; k < m; k++) begin
            if (((a * k) % m) == 1 && r == 0) r = k;
        end
        return r;
    endfunction

endpackage

// File: rtl/rns_mr_seq.sv
module rns_mr_seq
    import rns_mr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       load,
    output logic       sub_en,
    output logic       mul_en,
    output logic [1:0] stage,
    output logic       emit,
    output logic       busy
);

    phase_e     ph_q;
    logic [2:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            step_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q   <= PH_STEP;
                        step_q <= '0;
                    end
                end
                PH_STEP: begin
                    if (step_q == 3'(STEPS - 1)) ph_q <= PH_EMIT;
                    else                         step_q <= step_q + 3'd1;
                end
                PH_EMIT: ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        load   = (ph_q == PH_IDLE) && start;
        sub_en = (ph_q == PH_STEP) && !step_q[0];
        mul_en = (ph_q == PH_STEP) &&  step_q[0];
        stage  = step_q[2:1];
        emit   = (ph_q == PH_EMIT);
        busy   = (ph_q != PH_IDLE);
    end

endmodule

// File: rtl/rns_mr_lane.sv
module rns_mr_lane
    import rns_mr_pkg::*;
#(
    parameter int MOD  = 31,
    parameter int LANE = 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [RW-1:0] load_val,
    input  logic          sub_en,
    input  logic          mul_en,
    input  logic [1:0]    stage,
    input  logic [RW-1:0] digit,
    output logic [RW-1:0] value
);

    // inverses of the earlier moduli taken modulo this lane's modulus
    localparam int INV0 = modinv(modulus(0) % MOD, MOD);
    localparam int INV1 = (LANE > 1) ? modinv(modulus(1) % MOD, MOD) : 1;
    localparam int INV2 = (LANE > 2) ? modinv(modulus(2) % MOD, MOD) : 1;
    localparam logic [MW-1:0] MODW = MW'(MOD);

    logic [RW-1:0] v_q;
    logic [MW-1:0] v_ext;
    logic [MW-1:0] d_red;
    logic [MW-1:0] factor;
    logic [RW-1:0] nxt_sub;
    logic [RW-1:0] nxt_mul;
    logic          active;

    always_comb begin
        active = (LANE > int'(stage));
        v_ext  = MW'(v_q);
        d_red  = MW'(digit) % MODW;
        case (stage)
            2'd0:    factor = MW'(INV0);
            2'd1:    factor = MW'(INV1);
            default: factor = MW'(INV2);
        endcase
        nxt_sub = RW'((v_ext + MODW - d_red) % MODW);
        nxt_mul = RW'((v_ext * factor) % MODW);
    end

    always_ff @(posedge clk) begin
        if (rst)                  v_q <= '0;
        else if (load)            v_q <= load_val;
        else if (active && sub_en) v_q <= nxt_sub;
        else if (active && mul_en) v_q <= nxt_mul;
    end

    assign value = v_q;

endmodule

// File: rtl/rns_mr_rebuild.sv
module rns_mr_rebuild
    import rns_mr_pkg::*;
(
    input  digits_t         dig,
    output logic [OUTW-1:0] value,
    output logic            neg
);

    logic [TW-1:0]   a4;
    logic [TW-1:0]   t1;
    logic [TW-1:0]   t2;
    logic [OUTW-1:0] x;

    always_comb begin
        a4    = TW'(dig.p4);
        // p4*63 + p3, then *31 + p2, each as shift-and-subtract
        t1    = (a4 << K3) - a4 + TW'(dig.p3);
        t2    = (t1 << K2) - t1 + TW'(dig.p2);
        x     = {t2, dig.p1};
        neg   = (x >= OUTW'(HALF_M));
        value = neg ? (x - OUTW'(RANGE_M)) : x;
    end

endmodule

// File: rtl/rns_mr_converter.sv
module rns_mr_converter
    import rns_mr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [K1-1:0]          res_m128,
    input  logic [K2-1:0]          res_m31,
    input  logic [K3-1:0]          res_m63,
    input  logic [K4-1:0]          res_m127,
    output logic                   busy,
    output logic                   done,
    output logic signed [OUTW-1:0] value,
    output logic                   is_neg
);

    logic            load, sub_en, mul_en, emit;
    logic [1:0]      stage;
    logic [RW-1:0]   p1_q;
    logic [RW-1:0]   in_res [NCH];
    logic [RW-1:0]   lane_q [1:NCH-1];
    logic [RW-1:0]   sel_digit;
    digits_t         dig;
    logic [OUTW-1:0] rb_val;
    logic            rb_neg;

    rns_mr_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .load   (load),
        .sub_en (sub_en),
        .mul_en (mul_en),
        .stage  (stage),
        .emit   (emit),
        .busy   (busy)
    );

    always_comb begin
        in_res[0] = RW'(res_m128);
        in_res[1] = RW'(res_m31);
        in_res[2] = RW'(res_m63);
        in_res[3] = RW'(res_m127);
    end

    // the power-of-two channel is the first digit as captured
    always_ff @(posedge clk) begin
        if (rst)       p1_q <= '0;
        else if (load) p1_q <= in_res[0];
    end

    // digit consumed in the current round
    always_comb begin
        case (stage)
            2'd0:    sel_digit = p1_q;
            2'd1:    sel_digit = lane_q[1];
            default: sel_digit = lane_q[2];
        endcase
    end

    for (genvar g = 1; g < NCH; g++) begin : g_lane
        rns_mr_lane #(
            .MOD  (modulus(g)),
            .LANE (g)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (in_res[g]),
            .sub_en   (sub_en),
            .mul_en   (mul_en),
            .stage    (stage),
            .digit    (sel_digit),
            .value    (lane_q[g])
        );
    end

    always_comb begin
        dig.p1 = p1_q;
        dig.p2 = lane_q[1];
        dig.p3 = lane_q[2];
        dig.p4 = lane_q[3];
    end

    rns_mr_rebuild u_rebuild (
        .dig   (dig),
        .value (rb_val),
        .neg   (rb_neg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= '0;
            is_neg <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= emit;
            if (emit) begin
                value  <= rb_val;
                is_neg <= rb_neg;
            end
        end
    end

endmodule

// File: rtl/rns_mr_checker.sv
module rns_mr_checker
    import rns_mr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [OUTW-1:0] value,
    input logic            is_neg,
    input digits_t         dig
);

    logic [3:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (start && !busy)          cnt_q <= 4'd1;
        else if (busy && cnt_q != 4'hF)   cnt_q <= cnt_q + 4'd1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_q == 4'(CONV_CYCLES))); // R2
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R3
    AST_DIGIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (dig.p2 < RW'(MOD2) && dig.p3 < RW'(MOD3) && dig.p4 < RW'(MOD4))); // R4
    AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
        done |-> (is_neg == value[OUTW-1])); // R5
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        done |-> (value[K1-1:0] == dig.p1)); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(value) && $stable(is_neg))); // R7

endmodule

bind rns_mr_converter rns_mr_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .value  (value),
    .is_neg (is_neg),
    .dig    (dig)
);

// File: tb/rns_mr_converter_test.sv
`timescale 1ns/1ps
module rns_mr_converter_test;

    localparam int M    = 31747968;
    localparam int HALF = M / 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [6:0]        res_m128 = '0;
    logic [4:0]        res_m31 = '0;
    logic [5:0]        res_m63 = '0;
    logic [6:0]        res_m127 = '0;
    logic              busy, done, is_neg;
    logic signed [24:0] value;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rns_mr_converter uut (
        .clk(clk), .rst(rst), .start(start),
        .res_m128(res_m128), .res_m31(res_m31), .res_m63(res_m63), .res_m127(res_m127),
        .busy(busy), .done(done), .value(value), .is_neg(is_neg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference encoder: signed value -> least residues
    task automatic put_residues(input int v);
        int x;
        x = (v < 0) ? v + M : v;
        res_m128 = 7'(x % 128);
        res_m31  = 5'(x % 31);
        res_m63  = 6'(x % 63);
        res_m127 = 7'(x % 127);
    endtask

    // drive at a falling edge, return falling edges until done
    task automatic convert(input int v, output int lat);
        @(negedge clk);
        put_residues(v);
        start = 1'b1;
        lat = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
            if (done) break;
        end
    endtask

    task automatic run_one(input int v, input string req);
        int lat;
        int lowexp;
        convert(v, lat);
        lowexp = ((v < 0) ? v + M : v) % 128;
        check(lat == 8, "R2", "done latency", lat, 8);
        check(int'(value) == v, req, "value", int'(value), v);
        check(is_neg == (v < 0), req, "sign", is_neg, (v < 0));
        check(int'(value[6:0]) == lowexp, "R6", "low bits", int'(value[6:0]), lowexp);
    endtask

    task automatic t_reset;
        check(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
        check(value == 0 && is_neg == 0, "R1", "result in reset", int'(value), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && value == 0 && is_neg == 0,
              "R1", "state after release", int'(value), 0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        put_residues(777);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1, "R2", "busy after accept", busy, 1);
        for (int k = 2; k <= 7; k++) @(negedge clk);
        check(done == 0, "R2", "no early done", done, 0);
        @(negedge clk);
        check(done == 1 && busy == 0, "R2", "done with busy low", {done, busy}, 2);
        @(negedge clk);
        check(done == 0, "R2", "done one cycle", done, 0);
        check(int'(value) == 777, "R4", "handshake value", int'(value), 777);
    endtask

    task automatic t_positive;
        run_one(1, "R4");
        run_one(128, "R4");
        run_one(12345, "R4");
        run_one(249984, "R4");
        run_one(9876543, "R4");
    endtask

    task automatic t_negative;
        run_one(-1000, "R5");
        run_one(-128, "R5");
        run_one(-249983, "R5");
        run_one(-7777777, "R5");
        run_one(-15873983, "R5");
    endtask

    task automatic t_bounds;
        run_one(0, "R8");
        run_one(HALF - 1, "R8");
        run_one(-HALF, "R8");
        run_one(-1, "R8");
    endtask

    task automatic t_random;
        int unsigned s;
        int v;
        s = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            s ^= s << 13;
            s ^= s >> 17;
            s ^= s << 5;
            v = int'(s % 32'(M)) - HALF;
            run_one(v, (v < 0) ? "R5" : "R4");
        end
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        put_residues(4242);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        put_residues(-55555);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 5; k <= 7; k++) @(negedge clk);
        @(negedge clk);
        check(done == 1, "R3", "done on schedule", done, 1);
        check(int'(value) == 4242, "R3", "first request result", int'(value), 4242);
        @(negedge clk);
        check(busy == 0, "R3", "no queued restart", busy, 0);
        for (int k = 0; k < 10; k++) @(negedge clk);
        check(done == 0 && busy == 0, "R3", "stays idle", {done, busy}, 0);
    endtask

    task automatic t_hold;
        bit seen;
        run_one(-31337, "R5");
        seen = 1'b0;
        put_residues(500000);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(!seen, "R7", "no done without start", seen, 0);
        check(int'(value) == -31337, "R7", "value held", int'(value), -31337);
        check(is_neg == 1, "R7", "sign held", is_neg, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_handshake();
        t_positive();
        t_negative();
        t_bounds();
        t_busy_ignore();
        t_hold();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule